// File: doc/BRIEF.md
# Received Frame Status Queue

This block keeps one status record for each frame that an infrared serial receiver completes. When the receive framer finishes a frame, it pulses a push strobe and presents the frame's byte count and its error flags. The record goes into an eight-entry first-in, first-out queue. The host, or a DMA engine, then drains the queue one frame at a time.

The oldest record is seen through a byte-wide read port with three views, chosen by a selector:
- the low part of the length,
- the high part of the length,
- the error flags.

The length views can be read any number of times. A read strobe on the error view retires the record. The host uses the lengths to find the frame boundaries in the separate data FIFO, and uses the error flags to decide which frames to request again.

A programmable fill threshold drives a request output. Because of it, the host or DMA is signalled only once several frames have gathered, rather than once per frame. A push into a full queue is dropped and sets a sticky overflow flag. A synchronous clear empties the queue.

Top module: `rxsf_status_fifo`

## Requirements
- R1: The queue holds up to 8 records. `count_o` gives the number held. `empty_o` is high exactly when the count is 0, and `full_o` is high exactly when it is 8.
- R2: A clock edge with `push_i` high stores `len_i` (13 bits) and `err_i` (5 bits) as one record, provided the queue is not full. Records are read back in the order they were pushed.
- R3: `rd_sel_i` = 0 shows bits 7:0 of the oldest record's length on `rd_data_o`. `rd_sel_i` = 1 shows bits 12:8 of that length in `rd_data_o[4:0]`, with the upper bits zero.
- R4: `rd_sel_i` = 2 shows the oldest record's error flags in `rd_data_o[4:0]`, with the upper bits zero. A clock edge with `rd_en_i` high and `rd_sel_i` = 2 removes that record. `rd_sel_i` = 3 always reads zero.
- R5: A clock edge with `rd_en_i` high and `rd_sel_i` equal to 0, 1 or 3 removes nothing, and the oldest record stays visible.
- R6: While the queue is empty, every view reads zero. An error-view read strobe then changes neither the count nor the pointers, so a later push is read back correctly.
- R7: A push while full, with no removal on the same edge, is dropped and sets `ovf_o`. `ovf_o` stays high until `clr_i` or reset.
- R8: When full, a push on the same edge as an error-view read is accepted: the oldest record leaves, the new one enters, and the count stays 8.
- R9: `req_o` is high while `count_o` >= `thr_i`, where a `thr_i` of 0 acts as 1. It follows `thr_i` and `count_o` with no register between them.
- R10: A clock edge with `clr_i` high empties the queue and clears `ovf_o`. `clr_i` takes priority over a push and over a read on the same edge.
- R11: After `rst_ni` is asserted, the queue is empty, `ovf_o` and `req_o` are low, and `rd_data_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous queue clear |
| push_i | input | 1 | Frame complete; store a record |
| len_i | input | 13 | Frame byte length |
| err_i | input | 5 | Frame error flags |
| rd_en_i | input | 1 | Read strobe for the selected view |
| rd_sel_i | input | 2 | View select: 0 length low, 1 length high, 2 error flags, 3 zero |
| thr_i | input | 4 | Request threshold, 1 to 8 |
| rd_data_o | output | 8 | Selected view of the oldest record |
| count_o | output | 4 | Records held |
| full_o | output | 1 | Queue holds 8 records |
| empty_o | output | 1 | Queue holds no records |
| ovf_o | output | 1 | Sticky flag for a dropped push |
| req_o | output | 1 | Fill threshold reached |

## Verification
The bench builds the block with its default parameters:
- 8 entries,
- a 13-bit length split 8/5,
- 5 error flags.

With these values, random push and read traffic regularly reaches both the full and the empty boundary, and the pointer wrap past entry 7 is exercised many times. With a 13-bit length, a length above 255 can be drawn, so the high view returns non-zero bits. The threshold input is swept over every value from 0 to 8, which covers both the forced minimum of 1 and the request at the full depth.

// File: rtl/rxsf_pkg.sv
package rxsf_pkg;
  typedef enum logic [1:0] {
    SEL_LEN_LO = 2'd0,
    SEL_LEN_HI = 2'd1,
    SEL_STAT   = 2'd2,
    SEL_NONE   = 2'd3
  } rd_sel_e;
endpackage

// File: rtl/rxsf_ptr_ctrl.sv
module rxsf_ptr_ctrl #(
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic             pop_req_i,
  output logic             wr_en_o,
  output logic [PTR_W-1:0] wptr_o,
  output logic [PTR_W-1:0] rptr_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(DEPTH - 1);

  logic pop, wr;

  assign empty_o = (count_o == '0);
  assign full_o  = (count_o == CNT_MAX);
  assign pop     = pop_req_i && !empty_o && !clr_i;
  // a pop on the same edge frees the slot for a push into a full queue
  assign wr      = push_i && !clr_i && (!full_o || pop);
  assign wr_en_o = wr;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_MAX) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_o  <= '0;
      rptr_o  <= '0;
      count_o <= '0;
      ovf_o   <= 1'b0;
    end else if (clr_i) begin
      wptr_o  <= '0;
      rptr_o  <= '0;
      count_o <= '0;
      ovf_o   <= 1'b0;
    end else begin
      if (wr)  wptr_o <= nxt(wptr_o);
      if (pop) rptr_o <= nxt(rptr_o);
      if (wr && !pop)      count_o <= count_o + 1'b1;
      else if (pop && !wr) count_o <= count_o - 1'b1;
      if (push_i && full_o && !pop) ovf_o <= 1'b1;
    end
  end
endmodule

// File: rtl/rxsf_store.sv
module rxsf_store #(
  parameter int DEPTH = 8,
  parameter int LEN_W = 13,
  parameter int ERR_W = 5,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [PTR_W-1:0] wptr_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [ERR_W-1:0] err_i,
  input  logic [PTR_W-1:0] rptr_i,
  output logic [LEN_W-1:0] len_o,
  output logic [ERR_W-1:0] err_o
);
  logic [LEN_W-1:0] len_q [DEPTH];
  logic [ERR_W-1:0] err_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        len_q[i] <= '0;
        err_q[i] <= '0;
      end else if (wr_en_i && (wptr_i == PTR_W'(i))) begin
        len_q[i] <= len_i;
        err_q[i] <= err_i;
      end
    end
  end

  assign len_o = len_q[rptr_i];
  assign err_o = err_q[rptr_i];
endmodule

// File: rtl/rxsf_rd_mux.sv
module rxsf_rd_mux
  import rxsf_pkg::*;
#(
  parameter int LEN_W  = 13,
  parameter int ERR_W  = 5,
  parameter int DATA_W = 8
) (
  input  logic [LEN_W-1:0]  len_i,
  input  logic [ERR_W-1:0]  err_i,
  input  logic              empty_i,
  input  logic [1:0]        sel_i,
  output logic [DATA_W-1:0] data_o
);
  always_comb begin
    data_o = '0;
    if (!empty_i) begin
      unique case (rd_sel_e'(sel_i))
        SEL_LEN_LO: data_o = len_i[DATA_W-1:0];
        SEL_LEN_HI: data_o = DATA_W'(len_i >> DATA_W);
        SEL_STAT:   data_o = DATA_W'(err_i);
        default:    data_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/rxsf_status_fifo.sv
module rxsf_status_fifo
  import rxsf_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int LEN_W  = 13,
  parameter int ERR_W  = 5,
  parameter int DATA_W = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              push_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [ERR_W-1:0]  err_i,
  input  logic              rd_en_i,
  input  logic [1:0]        rd_sel_i,
  input  logic [CNT_W-1:0]  thr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              ovf_o,
  output logic              req_o
);
  logic             wr_en, pop_req;
  logic [PTR_W-1:0] wptr, rptr;
  logic [LEN_W-1:0] head_len;
  logic [ERR_W-1:0] head_err;
  logic [CNT_W-1:0] thr_eff;

  assign pop_req = rd_en_i && (rd_sel_e'(rd_sel_i) == SEL_STAT);

  rxsf_ptr_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk_i, .rst_ni, .clr_i, .push_i,
    .pop_req_i(pop_req), .wr_en_o(wr_en),
    .wptr_o(wptr), .rptr_o(rptr),
    .count_o, .full_o, .empty_o, .ovf_o
  );

  rxsf_store #(.DEPTH(DEPTH), .LEN_W(LEN_W), .ERR_W(ERR_W)) store_i (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wptr_i(wptr),
    .len_i, .err_i, .rptr_i(rptr),
    .len_o(head_len), .err_o(head_err)
  );

  rxsf_rd_mux #(.LEN_W(LEN_W), .ERR_W(ERR_W), .DATA_W(DATA_W)) mux_i (
    .len_i(head_len), .err_i(head_err), .empty_i(empty_o),
    .sel_i(rd_sel_i), .data_o(rd_data_o)
  );

  // threshold 0 is treated as 1
  assign thr_eff = (thr_i == '0) ? CNT_W'(1) : thr_i;
  assign req_o   = (count_o >= thr_eff);
endmodule

// File: rtl/rxsf_status_fifo_chk.sv
module rxsf_status_fifo_chk #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clr_i,
  input logic              push_i,
  input logic              rd_en_i,
  input logic [1:0]        rd_sel_i,
  input logic [CNT_W-1:0]  thr_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic [CNT_W-1:0]  count_o,
  input logic              full_o,
  input logic              empty_o,
  input logic              ovf_o,
  input logic              req_o
);
  logic st_rd, len_rd;
  assign st_rd  = rd_en_i && (rd_sel_i == 2'd2);
  assign len_rd = rd_en_i && (rd_sel_i != 2'd2);

  assert_count_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CNT_W'(DEPTH));

  assert_full_count_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> (count_o == CNT_W'(DEPTH)) && !empty_o);

  assert_push_grows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !full_o && !rd_en_i && !clr_i) |=> count_o == $past(count_o) + 1'b1);

  assert_pop_shrinks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_rd && !empty_o && !push_i && !clr_i) |=> count_o == $past(count_o) - 1'b1);

  assert_len_read_keeps_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (len_rd && !push_i && !clr_i) |=> $stable(count_o));

  assert_empty_reads_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> rd_data_o == '0);

  assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !st_rd && !clr_i) |=> ovf_o && full_o);

  assert_ovf_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !clr_i) |=> ovf_o);

  assert_swap_full_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && st_rd && !clr_i) |=> full_o && !ovf_o == !$past(ovf_o));

  assert_req_empty_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !req_o);

  assert_req_full_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> req_o);

  assert_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> empty_o && !ovf_o);
endmodule

bind rxsf_status_fifo rxsf_status_fifo_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .push_i(push_i),
  .rd_en_i(rd_en_i), .rd_sel_i(rd_sel_i), .thr_i(thr_i),
  .rd_data_o(rd_data_o), .count_o(count_o), .full_o(full_o),
  .empty_o(empty_o), .ovf_o(ovf_o), .req_o(req_o)
);

// File: tb/rxsf_status_fifo_tb.sv
module rxsf_status_fifo_tb_top;
  localparam int CLK_P = 10;
  localparam int DEPTH = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clr_i = 1'b0, push_i = 1'b0, rd_en_i = 1'b0;
  logic [12:0] len_i = '0;
  logic [4:0]  err_i = '0;
  logic [1:0]  rd_sel_i = '0;
  logic [3:0]  thr_i = 4'd1;
  logic [7:0]  rd_data_o;
  logic [3:0]  count_o;
  logic        full_o, empty_o, ovf_o, req_o;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  logic [12:0] m_len [$];
  logic [4:0]  m_err [$];
  bit          m_ovf = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  rxsf_status_fifo dut_i (.*);

  task automatic chk(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(logic [1:0] sel);
    if (m_len.size() == 0) return 8'd0;
    case (sel)
      2'd0: return m_len[0][7:0];
      2'd1: return {3'b0, m_len[0][12:8]};
      2'd2: return {3'b0, m_err[0]};
      default: return 8'd0;
    endcase
  endfunction

  function automatic bit exp_req();
    int t = (thr_i == 0) ? 1 : int'(thr_i);
    return m_len.size() >= t;
  endfunction

  task automatic check_state(string tag);
    chk(count_o == 4'(m_len.size()), {tag, " R1 count"}, count_o, m_len.size());
    chk(full_o == (m_len.size() == DEPTH), {tag, " R1 full"}, full_o, m_len.size() == DEPTH);
    chk(empty_o == (m_len.size() == 0), {tag, " R1 empty"}, empty_o, m_len.size() == 0);
    chk(ovf_o == m_ovf, {tag, " R7 ovf"}, ovf_o, m_ovf);
    chk(req_o == exp_req(), {tag, " R9 req"}, req_o, exp_req());
  endtask

  // inputs set just after a rising edge; combinational views checked before the next edge
  task automatic cyc(bit push, logic [12:0] len, logic [4:0] err,
                     bit rd, logic [1:0] sel, bit clr, string tag);
    bit pop;
    push_i = push; len_i = len; err_i = err;
    rd_en_i = rd; rd_sel_i = sel; clr_i = clr;
    #1;
    chk(rd_data_o == exp_rd(sel), {tag, " R3 R4 R6 view"}, rd_data_o, exp_rd(sel));
    chk(req_o == exp_req(), {tag, " R9 req comb"}, req_o, exp_req());
    pop = rd && sel == 2'd2 && m_len.size() > 0 && !clr;
    if (clr) begin
      m_len.delete(); m_err.delete(); m_ovf = 0;
    end else begin
      if (pop) begin void'(m_len.pop_front()); void'(m_err.pop_front()); end
      if (push) begin
        if (m_len.size() < DEPTH) begin m_len.push_back(len); m_err.push_back(err); end
        else m_ovf = 1;
      end
    end
    @(posedge clk_i); #1;
    push_i = 0; rd_en_i = 0; clr_i = 0;
    check_state(tag);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    #(CLK_P * 2 + 1);
    // R11 reset state
    chk(empty_o && !full_o && !ovf_o && !req_o && count_o == 0, "R11 reset flags", count_o, 0);
    chk(rd_data_o == 0, "R11 reset data", rd_data_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(posedge clk_i); #1;
    check_state("R11 post");

    // R6 empty status read does not move pointers
    cyc(0, 0, 0, 1, 2'd2, 0, "R6 empty read");
    cyc(1, 13'h1abc, 5'h15, 0, 2'd0, 0, "R2 push one");
    cyc(0, 0, 0, 0, 2'd1, 0, "R3 hi view");
    cyc(0, 0, 0, 1, 2'd0, 0, "R5 lo read");
    cyc(0, 0, 0, 1, 2'd1, 0, "R5 hi read");
    cyc(0, 0, 0, 1, 2'd3, 0, "R4 sel3 read");
    cyc(0, 0, 0, 1, 2'd2, 0, "R4 pop");

    // R1 R7 fill past full
    thr_i = 4'd8;
    for (int i = 0; i < DEPTH; i++) cyc(1, 13'(i * 777 + 3), 5'(i + 1), 0, 2'd0, 0, "R2 fill");
    cyc(1, 13'h0fff, 5'h1f, 0, 2'd0, 0, "R7 drop");
    cyc(1, 13'h0eee, 5'h0e, 1, 2'd1, 0, "R7 drop with len read");
    // R8 swap while full
    cyc(1, 13'h1357, 5'h0a, 1, 2'd2, 0, "R8 swap");
    // R9 sweep threshold
    for (int t = 0; t <= DEPTH; t++) begin thr_i = 4'(t); cyc(0, 0, 0, 0, 2'd2, 0, "R9 sweep"); end
    for (int i = 0; i < DEPTH; i++) begin
      thr_i = 4'd4; cyc(0, 0, 0, 1, 2'd2, 0, "R4 drain");
    end
    chk(ovf_o == 1, "R7 sticky after drain", ovf_o, 1);
    // R10 clear has priority
    cyc(1, 13'h0123, 5'h01, 0, 2'd0, 0, "R2 pre clear");
    cyc(1, 13'h0456, 5'h02, 1, 2'd2, 1, "R10 clear");

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      bit p = ($urandom % 100) < 55;
      bit r = ($urandom % 100) < 45;
      bit c = ($urandom % 400) == 0;
      thr_i = 4'($urandom % 9);
      cyc(p, 13'($urandom), 5'($urandom), r, 2'($urandom), c, "rand R2 R4 R8");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule